// File: doc/BRIEF.md
# Wide Image Stride Splitter

The stride splitter turns one resize job into a stream of per-stride geometry descriptors. A job is given by a source crop (left edge, width) and a destination crop (left edge, top edge, width, height) together with flip and plane options. The block cuts the source into vertical slices of at most `SLICE_W` pixels. For each slice it works out the source left edge and width, and the destination left edge and width that the slice maps to. The destination positions are scaled from the source offsets by integer division.

For a destination with more than one plane, every stride yields a luma descriptor followed by a chroma descriptor. A half-height chroma plane reports half the destination height. Horizontal and vertical flips move the destination origin to the far edge. Descriptors leave on a valid/ready handshake. The final descriptor carries a last flag. Jobs whose source width cannot be covered by `MAX_STRIDES` slices are refused with a one-cycle reject pulse. A sequential divider performs the proportional arithmetic, so each stride costs a few dozen cycles.

Top module: `stride_splitter`

## Requirements
- R1: Each descriptor's source width is the smaller of `SLICE_W` (default 2048) and the source width minus the stride offset. Its source x is the source left edge plus that offset.
- R2: The stride offset starts at 0 and grows by `SLICE_W` per stride. The job ends once the offset reaches or passes the source width, so a job has ceil(src_width / SLICE_W) strides.
- R3: Without horizontal flip, the destination x is dst_left + floor(offset × dst_width / src_width).
- R4: The destination width of a descriptor is floor(slice_src_width × dst_width / src_width).
- R5: A start with src_width = 0 or src_width > `SLICE_W` × `MAX_STRIDES` (default 8192) gives `job_reject` high for exactly one cycle, in the cycle after the start edge. No descriptor follows and `busy` stays low.
- R6: With `dst_multi_plane` = 1, each stride emits a descriptor with `desc_chroma` = 0 and then one with `desc_chroma` = 1. With `dst_multi_plane` = 0, only descriptors with `desc_chroma` = 0 are emitted.
- R7: A chroma descriptor with `dst_chroma_half` = 1 reports dst_height >> 1 as its height. Every other descriptor reports dst_height.
- R8: With `hflip` = 1, the destination x is dst_width − floor(offset × dst_width / src_width) − 1. With `vflip` = 1, the destination y is the reported height − 1. Otherwise y is dst_top.
- R9: Exactly one descriptor per job has `desc_last` = 1, and it is the final one. `busy` rises in the cycle after an accepted start and falls in the cycle after the last descriptor is accepted.
- R10: While `desc_valid` is high and `desc_ready` is low, `desc_valid` stays high and all descriptor fields hold their values.
- R11: A start pulse while `busy` is high has no effect on the running job's descriptors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a job with the job inputs sampled this edge |
| src_left | input | CW | Source crop left edge |
| src_width | input | CW | Source crop width |
| dst_left | input | CW | Destination crop left edge |
| dst_top | input | CW | Destination crop top edge |
| dst_width | input | CW | Destination crop width |
| dst_height | input | CW | Destination crop height |
| dst_multi_plane | input | 1 | Destination has separate chroma plane(s) |
| dst_chroma_half | input | 1 | Destination chroma is vertically half size |
| hflip | input | 1 | Horizontal flip |
| vflip | input | 1 | Vertical flip |
| busy | output | 1 | Job in progress |
| job_reject | output | 1 | One-cycle pulse: job refused |
| desc_valid | output | 1 | Descriptor available |
| desc_ready | input | 1 | Consumer accepts descriptor |
| desc_chroma | output | 1 | Descriptor targets the chroma plane |
| desc_last | output | 1 | Final descriptor of the job |
| desc_src_x | output | CW | Source left edge of the slice |
| desc_src_w | output | CW | Source width of the slice |
| desc_dst_x | output | CW | Destination x origin |
| desc_dst_y | output | CW | Destination y origin |
| desc_dst_w | output | CW | Destination width of the slice |
| desc_dst_h | output | CW | Destination height of the plane |

## Verification
A stale offset register shows up at once as a wrong `desc_src_x` on the second stride. A divider that stops short or latches the wrong operand shows as a wrong `desc_dst_x` or `desc_dst_w` on the first descriptor that needs a non-trivial quotient, about 70 cycles after start. A plane-sequencing error shows as a missing or doubled chroma descriptor, or as `desc_last` on the wrong descriptor. Such an error also changes the descriptor count before `busy` falls. Stalled-ready runs catch fields that change under back-pressure on the very next cycle.

// File: rtl/stride_pkg.sv
// Shared types of the stride splitter.
// Assumes: nothing beyond a SystemVerilog-2017 tool.
package stride_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_DIV_OFF = 3'd1,
        ST_DIV_W   = 3'd2,
        ST_LUMA    = 3'd3,
        ST_CHROMA  = 3'd4
    } split_state_t;
endpackage

// File: rtl/stride_divider.sv
// Restoring unsigned divider, one quotient bit per cycle.
// Does: quot = numer / denom, with done pulsing NW cycles after go.
// Assumes: denom != 0, and the true quotient fits in QW bits.
module stride_divider #(
    parameter int NW = 32,
    parameter int DW = 16,
    parameter int QW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [NW-1:0] numer,
    input  logic [DW-1:0] denom,
    output logic          done,
    output logic [QW-1:0] quot
);
    localparam int CNTW = $clog2(NW + 1);

    logic [NW-1:0]   q_r;
    logic [DW:0]     r_r;
    logic [CNTW-1:0] cnt_r;
    logic            run_r;
    logic [DW:0]     r_shift;
    logic [DW:0]     r_diff;
    logic            fits;

    // Trial subtraction of the shifted partial remainder.
    always_comb begin
        r_shift = {r_r[DW-1:0], q_r[NW-1]};
        r_diff  = r_shift - {1'b0, denom};
        fits    = (r_shift >= {1'b0, denom});
    end

    // Iteration state: load on go, shift one bit per cycle, flag completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_r   <= '0;
            r_r   <= '0;
            cnt_r <= '0;
            run_r <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                q_r   <= numer;
                r_r   <= '0;
                cnt_r <= CNTW'(NW);
                run_r <= 1'b1;
            end else if (run_r) begin
                r_r   <= fits ? r_diff : r_shift;
                q_r   <= {q_r[NW-2:0], fits};
                cnt_r <= cnt_r - 1'b1;
                if (cnt_r == CNTW'(1)) begin
                    run_r <= 1'b0;
                    done  <= 1'b1;
                end
            end
        end
    end

    assign quot = q_r[QW-1:0];
endmodule

// File: rtl/stride_geom.sv
// Combinational geometry of one stride and plane.
// Does: slice width, source x, flip-aware destination origin, plane height, last-stride test.
// Assumes: offset < src_w, and dst_off <= dst_w when hflip is used.
module stride_geom #(
    parameter int CW      = 16,
    parameter int SLICE_W = 2048
) (
    input  logic [CW-1:0] offset,
    input  logic [CW-1:0] src_left,
    input  logic [CW-1:0] src_w,
    input  logic [CW-1:0] dst_left,
    input  logic [CW-1:0] dst_top,
    input  logic [CW-1:0] dst_w,
    input  logic [CW-1:0] dst_h,
    input  logic [CW-1:0] dst_off,
    input  logic          chroma,
    input  logic          chroma_half,
    input  logic          hflip,
    input  logic          vflip,
    output logic [CW-1:0] slice_w,
    output logic [CW-1:0] slice_x,
    output logic [CW-1:0] out_x,
    output logic [CW-1:0] out_y,
    output logic [CW-1:0] out_h,
    output logic          last_stride
);
    localparam logic [CW-1:0] SLICE_C = CW'(SLICE_W);

    logic [CW-1:0] remain;
    logic [CW:0]   next_off;

    // Slice extent and whether this stride reaches the right edge.
    always_comb begin
        remain      = src_w - offset;
        slice_w     = (remain > SLICE_C) ? SLICE_C : remain;
        slice_x     = src_left + offset;
        next_off    = {1'b0, offset} + {1'b0, SLICE_C};
        last_stride = (next_off >= {1'b0, src_w});
    end

    // Destination origin and plane height for the current plane.
    always_comb begin
        out_h = (chroma && chroma_half) ? (dst_h >> 1) : dst_h;
        out_x = hflip ? (dst_w - dst_off - 1'b1) : (dst_left + dst_off);
        out_y = vflip ? (out_h - 1'b1) : dst_top;
    end
endmodule

// File: rtl/stride_splitter.sv
// Splits a resize job into per-stride geometry descriptors.
// Does: walks the source in SLICE_W steps, scales each slice onto the destination,
//       emits luma and optional chroma descriptors on valid/ready.
// Assumes: CW wide enough for SLICE_W*MAX_STRIDES + SLICE_W; job inputs are
//          sampled only on an accepted start.
module stride_splitter #(
    parameter int CW          = 16,
    parameter int SLICE_W     = 2048,
    parameter int MAX_STRIDES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] src_left,
    input  logic [CW-1:0] src_width,
    input  logic [CW-1:0] dst_left,
    input  logic [CW-1:0] dst_top,
    input  logic [CW-1:0] dst_width,
    input  logic [CW-1:0] dst_height,
    input  logic          dst_multi_plane,
    input  logic          dst_chroma_half,
    input  logic          hflip,
    input  logic          vflip,
    output logic          busy,
    output logic          job_reject,
    output logic          desc_valid,
    input  logic          desc_ready,
    output logic          desc_chroma,
    output logic          desc_last,
    output logic [CW-1:0] desc_src_x,
    output logic [CW-1:0] desc_src_w,
    output logic [CW-1:0] desc_dst_x,
    output logic [CW-1:0] desc_dst_y,
    output logic [CW-1:0] desc_dst_w,
    output logic [CW-1:0] desc_dst_h
);
    import stride_pkg::*;

    localparam int            PW      = 2 * CW;
    localparam int            LIMIT   = SLICE_W * MAX_STRIDES;
    localparam logic [CW-1:0] SLICE_C = CW'(SLICE_W);

    split_state_t  state;
    logic [CW-1:0] src_left_q, src_w_q, dst_left_q, dst_top_q, dst_w_q, dst_h_q;
    logic          multi_q, half_q, hflip_q, vflip_q;
    logic [CW-1:0] offset_q, dst_off_q, dst_sw_q;
    logic          div_go, div_done;
    logic [CW-1:0] div_quot;
    logic [CW-1:0] mul_a;
    logic [PW-1:0] div_numer;
    logic [CW-1:0] slice_w, slice_x, out_x, out_y, out_h;
    logic          last_stride, job_bad, accept;

    // Validity test of a new job's source width.
    always_comb job_bad = (src_width == '0) || (int'(src_width) > LIMIT);

    // Divider operand: stride offset first, slice width second.
    always_comb begin
        mul_a     = (state == ST_DIV_W) ? slice_w : offset_q;
        div_numer = PW'(mul_a) * PW'(dst_w_q);
    end

    stride_divider #(.NW(PW), .DW(CW), .QW(CW)) i_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (div_go),
        .numer (div_numer),
        .denom (src_w_q),
        .done  (div_done),
        .quot  (div_quot)
    );

    stride_geom #(.CW(CW), .SLICE_W(SLICE_W)) i_geom (
        .offset      (offset_q),
        .src_left    (src_left_q),
        .src_w       (src_w_q),
        .dst_left    (dst_left_q),
        .dst_top     (dst_top_q),
        .dst_w       (dst_w_q),
        .dst_h       (dst_h_q),
        .dst_off     (dst_off_q),
        .chroma      (state == ST_CHROMA),
        .chroma_half (half_q),
        .hflip       (hflip_q),
        .vflip       (vflip_q),
        .slice_w     (slice_w),
        .slice_x     (slice_x),
        .out_x       (out_x),
        .out_y       (out_y),
        .out_h       (out_h),
        .last_stride (last_stride)
    );

    // Handshake completion of the descriptor on the outputs.
    always_comb accept = desc_valid && desc_ready;

    // Sequencer: job capture, per-stride divisions, plane emission, advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            job_reject <= 1'b0;
            div_go     <= 1'b0;
            offset_q   <= '0;
            dst_off_q  <= '0;
            dst_sw_q   <= '0;
            src_left_q <= '0;
            src_w_q    <= '0;
            dst_left_q <= '0;
            dst_top_q  <= '0;
            dst_w_q    <= '0;
            dst_h_q    <= '0;
            multi_q    <= 1'b0;
            half_q     <= 1'b0;
            hflip_q    <= 1'b0;
            vflip_q    <= 1'b0;
        end else begin
            job_reject <= 1'b0;
            div_go     <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start && job_bad) begin
                        job_reject <= 1'b1;
                    end else if (start) begin
                        src_left_q <= src_left;
                        src_w_q    <= src_width;
                        dst_left_q <= dst_left;
                        dst_top_q  <= dst_top;
                        dst_w_q    <= dst_width;
                        dst_h_q    <= dst_height;
                        multi_q    <= dst_multi_plane;
                        half_q     <= dst_chroma_half;
                        hflip_q    <= hflip;
                        vflip_q    <= vflip;
                        offset_q   <= '0;
                        div_go     <= 1'b1;
                        state      <= ST_DIV_OFF;
                    end
                end
                ST_DIV_OFF: begin
                    if (div_done) begin
                        dst_off_q <= div_quot;
                        div_go    <= 1'b1;
                        state     <= ST_DIV_W;
                    end
                end
                ST_DIV_W: begin
                    if (div_done) begin
                        dst_sw_q <= div_quot;
                        state    <= ST_LUMA;
                    end
                end
                ST_LUMA, ST_CHROMA: begin
                    if (accept) begin
                        if (state == ST_LUMA && multi_q) begin
                            state <= ST_CHROMA;
                        end else if (last_stride) begin
                            state <= ST_IDLE;
                        end else begin
                            offset_q <= offset_q + SLICE_C;
                            div_go   <= 1'b1;
                            state    <= ST_DIV_OFF;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output fields come straight from held state, so they are stable under stall.
    always_comb begin
        busy        = (state != ST_IDLE);
        desc_valid  = (state == ST_LUMA) || (state == ST_CHROMA);
        desc_chroma = (state == ST_CHROMA);
        desc_last   = desc_valid && last_stride && ((state == ST_CHROMA) || !multi_q);
        desc_src_x  = slice_x;
        desc_src_w  = slice_w;
        desc_dst_x  = out_x;
        desc_dst_y  = out_y;
        desc_dst_w  = dst_sw_q;
        desc_dst_h  = out_h;
    end

    // R10: back-pressure keeps the descriptor in place.
    a_r10_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid && !desc_ready |=> desc_valid && $stable(desc_src_x) &&
        $stable(desc_dst_x) && $stable(desc_dst_w) && $stable(desc_chroma));

    // R1: a slice is never empty and never wider than SLICE_W.
    a_r1_slice_cap: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid |-> (desc_src_w != '0) && (desc_src_w <= SLICE_C));

    // R9: acceptance of the last descriptor ends the job.
    a_r9_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
        accept && desc_last |=> !busy);

    // R9: acceptance of any other descriptor keeps the job running.
    a_r9_not_last_runs: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !desc_last |=> busy);

    // R5: a refused job produces no activity.
    a_r5_reject_idle: assert property (@(posedge clk) disable iff (!rst_n)
        job_reject |-> !busy && !desc_valid);

    // R6: a chroma descriptor follows a luma descriptor of a multi-plane job.
    a_r6_chroma_order: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(desc_chroma) |-> $past(accept) && !$past(desc_chroma));
endmodule

// File: tb/test_stride_splitter.sv
// Directed bench of the stride splitter: one task per scenario.
module test_stride_splitter;
    localparam int CLK_P = 10;
    localparam int CW    = 16;
    localparam int SW    = 2048;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [CW-1:0] src_left = '0, src_width = '0, dst_left = '0, dst_top = '0;
    logic [CW-1:0] dst_width = '0, dst_height = '0;
    logic          dst_multi_plane = 1'b0, dst_chroma_half = 1'b0, hflip = 1'b0, vflip = 1'b0;
    logic          busy, job_reject, desc_valid, desc_chroma, desc_last;
    logic          desc_ready = 1'b0;
    logic [CW-1:0] desc_src_x, desc_src_w, desc_dst_x, desc_dst_y, desc_dst_w, desc_dst_h;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;

    stride_splitter i_stride_splitter (
        .clk(clk), .rst_n(rst_n), .start(start),
        .src_left(src_left), .src_width(src_width), .dst_left(dst_left), .dst_top(dst_top),
        .dst_width(dst_width), .dst_height(dst_height),
        .dst_multi_plane(dst_multi_plane), .dst_chroma_half(dst_chroma_half),
        .hflip(hflip), .vflip(vflip), .busy(busy), .job_reject(job_reject),
        .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_chroma(desc_chroma),
        .desc_last(desc_last), .desc_src_x(desc_src_x), .desc_src_w(desc_src_w),
        .desc_dst_x(desc_dst_x), .desc_dst_y(desc_dst_y), .desc_dst_w(desc_dst_w),
        .desc_dst_h(desc_dst_h)
    );

    always #(CLK_P / 2) clk = ~clk;

    // Watchdog: a hung run is a failed check and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: act=%0d exp<=150000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: act=%0d exp=%0d", tag, what, act, exp);
        end
    endtask

    // Runs one job and compares every descriptor with a model built from the requirements.
    task automatic run_job(input string name, input int sl, input int sw, input int dl,
                           input int dt, input int dw, input int dh, input bit mp,
                           input bit half, input bit hf, input bit vf,
                           input bit stall, input bit poke);
        int per, n_exp, idx, lasts, cyc;
        bit hold_prev;
        int prev_sx, prev_dx;
        per   = mp ? 2 : 1;
        n_exp = ((sw + SW - 1) / SW) * per;
        idx = 0; lasts = 0; cyc = 0; hold_prev = 0; prev_sx = 0; prev_dx = 0;
        @(negedge clk);
        src_left = CW'(sl); src_width = CW'(sw); dst_left = CW'(dl); dst_top = CW'(dt);
        dst_width = CW'(dw); dst_height = CW'(dh); dst_multi_plane = mp;
        dst_chroma_half = half; hflip = hf; vflip = vf; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R9", {name, " busy after start"}, int'(busy), 1);
        while (busy && cyc < 4000) begin
            cyc++;
            if (poke && cyc == 5) begin
                start = 1'b1; src_width = 16'd100; hflip = ~hf;
            end else begin
                start = 1'b0;
            end
            if (hold_prev) begin
                chk("R10", {name, " valid held"}, int'(desc_valid), 1);
                chk("R10", {name, " src_x held"}, int'(desc_src_x), prev_sx);
                chk("R10", {name, " dst_x held"}, int'(desc_dst_x), prev_dx);
            end
            desc_ready = stall ? (cyc % 3 == 0) : 1'b1;
            hold_prev  = desc_valid && !desc_ready;
            prev_sx = int'(desc_src_x); prev_dx = int'(desc_dst_x);
            if (desc_valid && desc_ready) begin
                int k, off, swid, doff, ew, x, h, y;
                bit ch, lst;
                k    = idx / per;
                ch   = mp && (idx % 2 == 1);
                off  = k * SW;
                swid = (sw - off < SW) ? sw - off : SW;
                doff = (off * dw) / sw;
                ew   = (swid * dw) / sw;
                x    = hf ? (dw - doff - 1) : (dl + doff);
                h    = (ch && half) ? dh / 2 : dh;
                y    = vf ? h - 1 : dt;
                lst  = (idx == n_exp - 1);
                chk("R1", {name, " src_x"}, int'(desc_src_x), (sl + off) & 16'hFFFF);
                chk("R1", {name, " src_w"}, int'(desc_src_w), swid);
                chk(hf ? "R8" : "R3", {name, " dst_x"}, int'(desc_dst_x), x & 16'hFFFF);
                chk("R4", {name, " dst_w"}, int'(desc_dst_w), ew);
                chk("R6", {name, " chroma"}, int'(desc_chroma), int'(ch));
                chk("R7", {name, " dst_h"}, int'(desc_dst_h), h);
                chk("R8", {name, " dst_y"}, int'(desc_dst_y), y & 16'hFFFF);
                chk("R9", {name, " last"}, int'(desc_last), int'(lst));
                if (desc_last) lasts++;
                idx++;
            end
            @(negedge clk);
        end
        desc_ready = 1'b0;
        start = 1'b0;
        chk("R2 R11", {name, " descriptor count"}, idx, n_exp);
        chk("R9", {name, " last count"}, lasts, 1);
        chk("R9", {name, " idle at end"}, int'(busy), 0);
    endtask

    // A refused job pulses reject once and emits nothing.
    task automatic run_reject(input string name, input int sw);
        int seen;
        seen = 0;
        @(negedge clk);
        src_width = CW'(sw); dst_width = 16'd100; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R5", {name, " reject pulse"}, int'(job_reject), 1);
        chk("R5", {name, " busy low"}, int'(busy), 0);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (desc_valid || busy || job_reject) seen++;
        end
        chk("R5", {name, " silent after reject"}, seen, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", "reset busy", int'(busy), 0);
        chk("R10", "reset valid", int'(desc_valid), 0);
        chk("R5", "reset reject", int'(job_reject), 0);
        run_job("narrow", 7, 1000, 3, 5, 500, 300, 0, 0, 0, 0, 0, 0);
        run_job("wide420", 10, 5000, 20, 8, 3000, 720, 1, 1, 0, 0, 1, 0);
        run_job("exact4096flip", 0, 4096, 0, 0, 1920, 1080, 1, 1, 1, 1, 0, 0);
        run_job("max8192", 0, 8192, 4, 2, 8192, 64, 0, 0, 1, 0, 1, 0);
        run_job("upscale", 1, 2049, 9, 3, 4000, 99, 1, 0, 0, 1, 0, 0);
        run_job("busy_start", 2, 3000, 1, 1, 1500, 40, 0, 0, 0, 0, 0, 1);
        run_reject("too_wide", 8193);
        run_reject("zero_width", 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule